// File: doc/BRIEF.md
# Second-order multi-bit noise-shaping modulator

This block turns a stream of oversampled 14-bit signed samples into a stream of 3-bit level codes for a multi-bit current-steering converter. It produces one code per accepted sample. The quantization error is shaped by a second-order high-pass response, so the in-band content of the output levels follows the input. Used this way, the block can reach 14-bit resolution over a 5 MHz band.

The loop has two delaying integrators, and the quantizer reads the second integrator's register. Both feedback gains are powers of two, 1 and 2, so the feedback is a shifted copy of the quantizer level and the loop uses no multiplier. Every adder input comes straight from a register. The input register and the output delay line add pipeline stages outside the loop. These stages set a fixed latency and leave the noise transfer function (1 - z^-1)^2 unchanged.

Top module: `dsm2_modulator`

## Requirements
- R1: A sample presented with `in_valid` high produces exactly one code, with `out_valid` high, LATENCY clock cycles later (default 3, minimum 2). `out_valid` is low at every other time.
- R2: With I1 and I2 starting at 0, the block behaves as follows for each accepted sample x, taken in order. The code c is computed from the current I2. Then I1 becomes I1 + x - L(c) and I2 becomes I2 + I1 - 2*L(c), both using the values before the update.
- R3: The code is c = floor(I2 / 2048) + 4, clamped to the range 0..7. It is sent as an unsigned 3-bit value. The matching feedback level is L(c) = (2c - 7) * 1024.
- R4: Each integrator update saturates at the signed 18-bit limits, -131072 and 131071, and never wraps.
- R5: While `in_valid` is low, both integrators hold their values, and the held-off cycle produces no output.
- R6: While `rst` is high at a clock edge, both integrators and all pipeline stages are cleared. After reset `out_valid` is low and `out_code` is 0.
- R7: For a constant input x with |x| <= 6144, the mean of L(c) over 32768 consecutive codes after reset matches x to within 1 LSB.
- R8: A sustained full-scale input drives the loop into saturation and the code to its end value, 0 for a negative input. Once the input returns in range, the block again follows R2 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 14 | Signed input sample |
| out_valid | output | 1 | Output code qualifier |
| out_code | output | 3 | Unsigned level code, 0..7 |

## Verification
A wrong integrator value changes the next quantizer decision, so a bad update shows in the code stream within one to two accepted samples. The difference keeps spreading afterwards, because the loop never forgets an error. The comparison against the bench's own model is therefore exact and sample by sample. A saturation fault or a wrap shows only after many samples in overload, and the full-scale run is there to catch it. A small gain error may shift only the long-term mean, so the DC runs bound the mean of the levels.

// File: rtl/dsm2_modulator.sv
module dsm2_modulator #(
  parameter int IN_W    = 14,
  parameter int ACC_W   = 18,
  parameter int CODE_W  = 3,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_sample,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code
);
  localparam int STEP_SH = IN_W - CODE_W;
  localparam int NLEV    = 1 << CODE_W;
  localparam int WW      = ACC_W + 2;
  localparam int TAIL    = LATENCY - 2;
  localparam logic signed [WW-1:0] MAXV = {{(WW-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [WW-1:0] MINV = {{(WW-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] QHI = ACC_W'(NLEV/2 - 1);
  localparam logic signed [ACC_W-1:0] QLO = -ACC_W'(NLEV/2);

  logic signed [IN_W-1:0]  xr;
  logic                    x_vld;
  logic signed [ACC_W-1:0] i1, i2, i2_sh;
  logic [CODE_W-1:0]       q, code_r;
  logic                    code_vld;
  logic signed [WW-1:0]    e_i1, e_i2, e_x, lev, s1, s2;

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [WW-1:0] s);
    if (s > MAXV)      return MAXV[ACC_W-1:0];
    else if (s < MINV) return MINV[ACC_W-1:0];
    else               return s[ACC_W-1:0];
  endfunction

  assign i2_sh = i2 >>> STEP_SH;

  always_comb begin
    if (i2_sh > QHI)      q = CODE_W'(NLEV - 1);
    else if (i2_sh < QLO) q = '0;
    else                  q = {~i2_sh[CODE_W-1], i2_sh[CODE_W-2:0]};
  end

  assign e_i1 = i1;
  assign e_i2 = i2;
  assign e_x  = xr;
  assign lev  = (($signed({{(WW-CODE_W){1'b0}}, q}) <<< 1) - WW'(NLEV - 1)) <<< (STEP_SH - 1);
  assign s1   = e_i1 + e_x - lev;
  assign s2   = e_i2 + e_i1 - (lev <<< 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      xr       <= '0;
      x_vld    <= 1'b0;
      i1       <= '0;
      i2       <= '0;
      code_r   <= '0;
      code_vld <= 1'b0;
    end else begin
      xr       <= in_sample;
      x_vld    <= in_valid;
      code_vld <= x_vld;
      if (x_vld) begin
        i1     <= sat(s1);
        i2     <= sat(s2);
        code_r <= q;
      end
    end
  end

  generate
    if (TAIL == 0) begin : g_direct
      assign out_valid = code_vld;
      assign out_code  = code_r;
    end else begin : g_tail
      logic              tv [TAIL];
      logic [CODE_W-1:0] tc [TAIL];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < TAIL; k++) begin
            tv[k] <= 1'b0;
            tc[k] <= '0;
          end
        end else begin
          tv[0] <= code_vld;
          tc[0] <= code_vld ? code_r : '0;
          for (int k = 1; k < TAIL; k++) begin
            tv[k] <= tv[k-1];
            tc[k] <= tc[k-1];
          end
        end
      end
      assign out_valid = tv[TAIL-1];
      assign out_code  = tc[TAIL-1];
    end
  endgenerate

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !x_vld |=> ($stable(i1) && $stable(i2)));

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    x_vld |=> ((($signed({i1[ACC_W-1], i1}) - $signed({$past(i1[ACC_W-1]), $past(i1)})) <= $signed((ACC_W+1)'(1 << IN_W))) &&
               (($signed({i1[ACC_W-1], i1}) - $signed({$past(i1[ACC_W-1]), $past(i1)})) >= -$signed((ACC_W+1)'(1 << IN_W)))));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (i1 == '0 && i2 == '0 && !code_vld && !x_vld));

  // R3
  code_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (x_vld && !i2[ACC_W-1]) |=> code_r[CODE_W-1]);
endmodule

// File: tb/test_dsm2_modulator.sv
`timescale 1ns/1ps
module test_dsm2_modulator;
  localparam int LAT = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [13:0] in_sample = '0;
  logic out_valid;
  logic [2:0] out_code;

  dsm2_modulator #(.IN_W(14), .ACC_W(18), .CODE_W(3), .LATENCY(LAT)) i_dsm2_modulator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_code(out_code));

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int m_i1 = 0, m_i2 = 0;
  logic hv [LAT];
  int   hc [LAT];
  bit   chk_on = 0;
  bit   dc_on = 0;
  longint dc_sum = 0;
  int   dc_n = 0;
  string tag = "R2";

  function automatic int mcode(int v2);
    int s;
    s = v2 >>> 11;
    s = s + 4;
    if (s > 7) s = 7;
    if (s < 0) s = 0;
    return s;
  endfunction
  function automatic int mlev(int c);
    return (2 * c - 7) * 1024;
  endfunction
  function automatic int msat(int v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  task automatic check(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int k = 0; k < LAT; k++) begin hv[k] = 0; hc[k] = 0; end
    m_i1 = 0; m_i2 = 0;
  endtask

  task automatic step(bit v, int x);
    int c, n1, n2;
    @(negedge clk);
    if (chk_on) begin
      check(out_valid == hv[LAT-1], {"R1 valid ", tag}, int'(out_valid), int'(hv[LAT-1]));
      if (hv[LAT-1]) begin
        check(int'(out_code) == hc[LAT-1], {"R2 code ", tag}, int'(out_code), hc[LAT-1]);
        if (dc_on) begin dc_sum += mlev(int'(out_code)); dc_n++; end
      end
    end
    for (int k = LAT-1; k > 0; k--) begin hv[k] = hv[k-1]; hc[k] = hc[k-1]; end
    hv[0] = v; hc[0] = 0;
    if (v) begin
      c = mcode(m_i2);
      hc[0] = c;
      n1 = msat(m_i1 + x - mlev(c));
      n2 = msat(m_i2 + m_i1 - 2 * mlev(c));
      m_i1 = n1; m_i2 = n2;
    end
    in_valid = v;
    in_sample = 14'(x);
  endtask

  task automatic do_reset();
    chk_on = 0;
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6 valid after reset", int'(out_valid), 0);
    check(out_code == 3'd0, "R6 code after reset", int'(out_code), 0);
    rst = 0;
    clear_hist();
    chk_on = 1;
  endtask

  task automatic dc_run(int x);
    longint diff;
    do_reset();
    tag = "R7 dc";
    dc_sum = 0; dc_n = 0; dc_on = 1;
    for (int k = 0; k < 32768; k++) step(1, x);
    for (int k = 0; k < LAT; k++) step(0, 0);
    dc_on = 0;
    check(dc_n == 32768, "R7 dc count", dc_n, 32768);
    diff = dc_sum - longint'(x) * dc_n;
    if (diff < 0) diff = -diff;
    check(diff <= longint'(dc_n), "R7 dc mean error*N", int'(diff), dc_n);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int x;
    bit v;
    process::self().srandom(32'h5eed1234);
    clear_hist();
    do_reset();
    // R1 R2 R3: directed small patterns
    tag = "R3 directed";
    step(1, 0); step(1, 8191); step(1, -8192); step(1, 4096);
    step(1, -2048); step(1, 2047); step(1, 0); step(1, 0);
    // R2 random with gaps (R5)
    tag = "R5 random gaps";
    for (int k = 0; k < 3000; k++) begin
      v = ($urandom % 4) != 0;
      x = int'($urandom % 12289) - 6144;
      step(v, x);
    end
    // R5 long hold: state must resume exactly
    tag = "R5 hold";
    for (int k = 0; k < 20; k++) step(0, 1234);
    for (int k = 0; k < 50; k++) step(1, int'($urandom % 12289) - 6144);
    // R4 R8 overload negative
    tag = "R4 overload";
    for (int k = 0; k < 600; k++) step(1, -8192);
    for (int k = 0; k < LAT; k++) step(1, -8192);
    check(out_code == 3'd0, "R8 code pinned at 0", int'(out_code), 0);
    tag = "R4 overload pos";
    for (int k = 0; k < 600; k++) step(1, 8191);
    for (int k = 0; k < LAT; k++) step(1, 8191);
    check(out_code == 3'd7, "R8 code pinned at 7", int'(out_code), 7);
    tag = "R8 recovery";
    for (int k = 0; k < 2000; k++) step(1, int'($urandom % 8193) - 4096);
    // R6 mid-run reset
    do_reset();
    tag = "R6 after reset";
    for (int k = 0; k < 200; k++) step(1, int'($urandom % 12289) - 6144);
    for (int k = 0; k < LAT; k++) step(0, 0);
    dc_run(3000);
    dc_run(-5555);
    chk_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule